// File: doc/BRIEF.md
# Flash Protection Register Gate

This block keeps the one-way protection word of an embedded flash array and applies it to every access that reaches the array. The word carries one code-protection bit and one lock bit per array block. A bit at 0 means "protected". A bit can be driven from 1 to 0 by a set-protection command, but never back to 1. The word sits in a register that survives the ordinary reset, which models non-volatile storage. A separate cold-start input loads it with all ones, as in a freshly made part.

Two volatile override flags sit beside the word. The first is a block override. It lets program and erase operations through to locked blocks until the next reset. The second is a code override. Code running from the flash turns it on and off by writing a special word to any flash address. While code protection is in force and the code override is off, a data read of the array from code that does not run from the flash returns a fixed dummy value in place of the array contents. A read-protection command makes reads return the protection word until the next write-type cycle arrives.

The array is decoded into a 16 KB block, two 8 KB blocks, a 32 KB block and then 64 KB blocks. Program and erase requests that hit a locked block are refused, and the refusal raises an error flag.

Top module: `flash_prot_gate`

## Requirements
- R1: A low `nv_init_n` at a clock edge loads the protection word with FFFFh. A low `rst_n` at a clock edge clears the block override, the code override, the read-protection mode and `err_flag`, and leaves the protection word unchanged.
- R2: A set-protection command (`set_valid`) replaces the word with the bitwise AND of the word and `set_data`. The new word is visible from the next cycle.
- R3: A set-protection command is rejected if `set_data` has a 1 in an implemented position that is already 0. A rejected command leaves the word unchanged and sets `err_flag` one cycle later. `err_flag` stays set until `err_clr` or `rst_n` clears it.
- R4: Blocks are decoded from the byte address. Block 0 is 00000h–03FFFh, block 1 is 04000h–05FFFh, block 2 is 06000h–07FFFh and block 3 is 08000h–0FFFFh. Block 3+k is the k-th 64 KB range from 10000h on. A program access (`acc_kind`=2) or an erase access (`acc_kind`=3) to a block whose bit is 0 drives `acc_allow` low and sets `err_flag`, unless the block override is on. Any other access drives `acc_allow` high.
- R5: A `btu_cmd` pulse turns the block override on. The override stays on until `rst_n` clears it.
- R6: Bit 15 at 0 means code protection is on. While it is on and the code override is off, a read access (`acc_kind`=0) with `acc_from_flash` low returns 009Bh on `rd_data`. A read with `acc_from_flash` high returns `arr_rdata`.
- R7: A write access (`acc_kind`=1) with data FFFFh and `acc_from_flash` high turns the code override on. Data FFFBh sent the same way turns it off. Any other data, or a write from outside the flash, leaves the override unchanged.
- R8: After a `rdprot_cmd` pulse, every read returns the protection word on `rd_data`. This lasts until a write, program or erase access, or a set-protection or block-override command, ends the mode.
- R9: Erase and program accesses never change the protection word.
- R10: Bits 11 to 14, and block bits at or above NUM_BLOCKS, always read as 1. Clear requests to these bits are ignored and do not cause a rejection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the volatile state |
| nv_init_n | input | 1 | Synchronous active-low cold-start load of the protection word to FFFFh |
| set_valid | input | 1 | Set-protection command strobe |
| set_data | input | 16 | New protection pattern (bits may only clear) |
| btu_cmd | input | 1 | Block override command strobe |
| rdprot_cmd | input | 1 | Read-protection command strobe |
| err_clr | input | 1 | Clears the error flag |
| acc_valid | input | 1 | Access strobe |
| acc_kind | input | 2 | 0 read, 1 write, 2 program, 3 erase |
| acc_addr | input | ADDR_W | Byte address inside the array |
| acc_wdata | input | 16 | Write data of the access |
| acc_from_flash | input | 1 | The issuing instruction was fetched from the flash |
| arr_rdata | input | 16 | Data from the array for the addressed word |
| acc_allow | output | 1 | Access is permitted |
| rd_data | output | 16 | Read data after protection substitution |
| err_flag | output | 1 | Sticky error flag |

## Verification
A wrong protection word shows up in two places. Reads taken after a read-protection command expose it directly. The allow signal exposes it on the next program or erase access to the block concerned. Both appear one cycle after the command that changed the word. A wrong override flag shows on the very next read from outside the flash, as a 009Bh where array data was expected or the other way round. A flag that survives reset shows as a program access that is let through after reset. The bench keeps its own copy of the expected word and reads the design's word back after every change to it.

// File: rtl/fpg_pkg.sv
// Shared definitions for the flash protection gate.
// Assumes a 16-bit protection word with the code bit at position 15.
package fpg_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_PROG  = 2'd2,
        ACC_ERASE = 2'd3
    } acc_kind_e;

    localparam int          WORD_W    = 16;
    localparam int          CODE_BIT  = 15;
    localparam int          MAX_BLK   = 11;
    localparam logic [15:0] DUMMY_RD  = 16'h009B;
    localparam logic [15:0] CODE_OPEN = 16'hFFFF;
    localparam logic [15:0] CODE_SHUT = 16'hFFFB;

    // Mask of implemented bits: the code bit plus nb block bits.
    function automatic logic [WORD_W-1:0] impl_mask(input int nb);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (i == CODE_BIT) || (i < nb);
        end
        return m;
    endfunction
endpackage

// File: rtl/prot_nvreg.sv
// Protection word store. Models non-volatile storage: only nv_init_n
// reloads it, never the ordinary reset. Bits can only go 1 -> 0.
// Assumes set_data is meaningful only while set_valid is high.
module prot_nvreg
    import fpg_pkg::*;
#(
    parameter int NUM_BLOCKS = 7
) (
    input  logic              clk,
    input  logic              nv_init_n,
    input  logic              set_valid,
    input  logic [WORD_W-1:0] set_data,
    output logic [WORD_W-1:0] prot_q,
    output logic              set_reject
);
    localparam logic [WORD_W-1:0] IMPL = impl_mask(NUM_BLOCKS);

    logic [WORD_W-1:0] raise_bits;

    // Purpose: find implemented positions the command would raise from 0 to 1.
    always_comb begin
        raise_bits = set_data & ~prot_q & IMPL;
        set_reject = set_valid && (raise_bits != '0);
    end

    // Purpose: cold-start load, then clear-only updates on accepted commands.
    always_ff @(posedge clk) begin
        if (!nv_init_n) begin
            prot_q <= '1;
        end else if (set_valid && !set_reject) begin
            prot_q <= prot_q & (set_data | ~IMPL);
        end
    end
endmodule

// File: rtl/prot_tmpflags.sv
// Volatile override flags and read-protection mode.
// Assumes a single-cycle strobe for each command and access.
module prot_tmpflags
    import fpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btu_cmd,
    input  logic              rdprot_cmd,
    input  logic              set_valid,
    input  logic              acc_valid,
    input  acc_kind_e         acc_kind,
    input  logic              acc_from_flash,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic              btu_q,
    output logic              ctu_q,
    output logic              rdmode_q
);
    logic flash_wr;
    logic leave_rd;

    // Purpose: classify the current cycle for the flag updates.
    always_comb begin
        flash_wr = acc_valid && (acc_kind == ACC_WRITE) && acc_from_flash;
        leave_rd = (acc_valid && (acc_kind != ACC_READ)) || set_valid || btu_cmd;
    end

    // Purpose: block override, sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            btu_q <= 1'b0;
        end else if (btu_cmd) begin
            btu_q <= 1'b1;
        end
    end

    // Purpose: code override, opened and shut by special words written from flash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctu_q <= 1'b0;
        end else if (flash_wr && (acc_wdata == CODE_OPEN)) begin
            ctu_q <= 1'b1;
        end else if (flash_wr && (acc_wdata == CODE_SHUT)) begin
            ctu_q <= 1'b0;
        end
    end

    // Purpose: read-protection mode, held until a write-type cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdmode_q <= 1'b0;
        end else if (rdprot_cmd) begin
            rdmode_q <= 1'b1;
        end else if (leave_rd) begin
            rdmode_q <= 1'b0;
        end
    end
endmodule

// File: rtl/prot_blkdec.sv
// Address to block index: 16K, 8K, 8K, 32K boot blocks, then 64K blocks.
// Assumes ADDR_W > 16 and byte addresses relative to the array base.
module prot_blkdec #(
    parameter int ADDR_W = 18,
    parameter int IDX_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  blk_idx
);
    logic [ADDR_W-17:0] upper;

    // Purpose: pick the boot block inside the first 64K, else a main block.
    always_comb begin
        upper = addr[ADDR_W-1:16];
        if (upper != '0) begin
            blk_idx = IDX_W'(3) + IDX_W'(upper);
        end else if (addr[15]) begin
            blk_idx = IDX_W'(3);
        end else if (!addr[14]) begin
            blk_idx = IDX_W'(0);
        end else if (!addr[13]) begin
            blk_idx = IDX_W'(1);
        end else begin
            blk_idx = IDX_W'(2);
        end
    end
endmodule

// File: rtl/prot_access_gate.sv
// Combinational gate: decides permission and the returned read data.
// Assumes prot_q already reads 1 in unimplemented positions.
module prot_access_gate
    import fpg_pkg::*;
#(
    parameter int NUM_BLOCKS = 7,
    parameter int IDX_W      = 3
) (
    input  logic              acc_valid,
    input  acc_kind_e         acc_kind,
    input  logic              acc_from_flash,
    input  logic [IDX_W-1:0]  blk_idx,
    input  logic [WORD_W-1:0] prot_q,
    input  logic              btu_q,
    input  logic              ctu_q,
    input  logic              rdmode_q,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic              acc_allow,
    output logic [WORD_W-1:0] rd_data,
    output logic              pe_refused
);
    localparam int SLOTS = 2 ** IDX_W;

    logic [SLOTS-1:0] blk_locked;
    logic             is_pe;
    logic             hide_code;

    // One lock flag per decodable index; indices past the array are never locked.
    for (genvar g = 0; g < SLOTS; g++) begin : g_lock
        if (g < NUM_BLOCKS) begin : g_impl
            assign blk_locked[g] = ~prot_q[g];
        end else begin : g_none
            assign blk_locked[g] = 1'b0;
        end
    end

    // Purpose: refuse program/erase on locked blocks without the override.
    always_comb begin
        is_pe      = (acc_kind == ACC_PROG) || (acc_kind == ACC_ERASE);
        pe_refused = acc_valid && is_pe && blk_locked[blk_idx] && !btu_q;
        acc_allow  = acc_valid && !pe_refused;
    end

    // Purpose: select protection word, dummy value or array data for reads.
    always_comb begin
        hide_code = !prot_q[CODE_BIT] && !ctu_q && !acc_from_flash;
        if (rdmode_q) begin
            rd_data = prot_q;
        end else if (acc_valid && (acc_kind == ACC_READ) && hide_code) begin
            rd_data = DUMMY_RD;
        end else begin
            rd_data = arr_rdata;
        end
    end
endmodule

// File: rtl/flash_prot_gate.sv
// Top of the flash protection gate: protection word, overrides, block
// decode and access gate, plus the sticky error flag.
// Assumes NUM_BLOCKS <= 11 and that all blocks fit below 2**ADDR_W.
module flash_prot_gate
    import fpg_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int NUM_BLOCKS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_init_n,
    input  logic              set_valid,
    input  logic [15:0]       set_data,
    input  logic              btu_cmd,
    input  logic              rdprot_cmd,
    input  logic              err_clr,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [15:0]       acc_wdata,
    input  logic              acc_from_flash,
    input  logic [15:0]       arr_rdata,
    output logic              acc_allow,
    output logic [15:0]       rd_data,
    output logic              err_flag
);
    localparam int IDX_W = $clog2(3 + 2 ** (ADDR_W - 16) + 1);

    logic [WORD_W-1:0] prot_q;
    logic              set_reject;
    logic              btu_q;
    logic              ctu_q;
    logic              rdmode_q;
    logic [IDX_W-1:0]  blk_idx;
    logic              pe_refused;
    acc_kind_e         kind;

    assign kind = acc_kind_e'(acc_kind);

    prot_nvreg #(.NUM_BLOCKS(NUM_BLOCKS)) nvreg_i (
        .clk        (clk),
        .nv_init_n  (nv_init_n),
        .set_valid  (set_valid),
        .set_data   (set_data),
        .prot_q     (prot_q),
        .set_reject (set_reject)
    );

    prot_tmpflags flags_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .btu_cmd        (btu_cmd),
        .rdprot_cmd     (rdprot_cmd),
        .set_valid      (set_valid),
        .acc_valid      (acc_valid),
        .acc_kind       (kind),
        .acc_from_flash (acc_from_flash),
        .acc_wdata      (acc_wdata),
        .btu_q          (btu_q),
        .ctu_q          (ctu_q),
        .rdmode_q       (rdmode_q)
    );

    prot_blkdec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dec_i (
        .addr    (acc_addr),
        .blk_idx (blk_idx)
    );

    prot_access_gate #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) gate_i (
        .acc_valid      (acc_valid),
        .acc_kind       (kind),
        .acc_from_flash (acc_from_flash),
        .blk_idx        (blk_idx),
        .prot_q         (prot_q),
        .btu_q          (btu_q),
        .ctu_q          (ctu_q),
        .rdmode_q       (rdmode_q),
        .arr_rdata      (arr_rdata),
        .acc_allow      (acc_allow),
        .rd_data        (rd_data),
        .pe_refused     (pe_refused)
    );

    // Purpose: sticky error on rejected commands or refused program/erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (set_reject || pe_refused) begin
            err_flag <= 1'b1;
        end else if (err_clr) begin
            err_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/fpg_checker.sv
// Property checker for flash_prot_gate, attached by bind below.
// Assumes the same parameters as the instance it watches.
module fpg_checker
    import fpg_pkg::*;
#(
    parameter int NUM_BLOCKS = 7,
    parameter int IDX_W      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nv_init_n,
    input logic              set_valid,
    input logic [15:0]       set_data,
    input logic              acc_valid,
    input logic [1:0]        acc_kind,
    input logic              acc_from_flash,
    input logic              acc_allow,
    input logic [15:0]       rd_data,
    input logic              err_flag,
    input logic [15:0]       prot_q,
    input logic              btu_q,
    input logic              ctu_q,
    input logic              rdmode_q,
    input logic [IDX_W-1:0]  blk_idx
);
    localparam logic [15:0] IMPL = impl_mask(NUM_BLOCKS);

    logic        armed;
    logic [15:0] prev_prot;

    // Purpose: remember the previous word once the cold-start load is done.
    always_ff @(posedge clk) begin
        if (!nv_init_n) begin
            armed     <= 1'b0;
            prev_prot <= '1;
        end else begin
            armed     <= 1'b1;
            prev_prot <= prot_q;
        end
    end

    a_r2_no_bit_rise: assert property (@(posedge clk) disable iff (!nv_init_n)
        armed |-> ((prot_q & ~prev_prot) == 16'h0));

    a_r3_reject_keeps: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
        (armed && set_valid && ((set_data & ~prot_q & IMPL) != 16'h0))
            |=> (prot_q == $past(prot_q)) && err_flag);

    a_r4_locked_refused: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        (acc_valid && acc_kind[1] && (int'(blk_idx) < NUM_BLOCKS)
            && !prot_q[blk_idx] && !btu_q) |-> !acc_allow);

    a_r5_flags_cleared: assert property (@(posedge clk)
        !rst_n |=> (!btu_q && !ctu_q && !rdmode_q));

    a_r6_dummy_read: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        (acc_valid && (acc_kind == 2'd0) && !prot_q[15] && !ctu_q
            && !acc_from_flash && !rdmode_q) |-> (rd_data == DUMMY_RD));

    a_r10_unimpl_ones: assert property (@(posedge clk) disable iff (!nv_init_n)
        armed |-> ((prot_q | IMPL) == 16'hFFFF));
endmodule

bind flash_prot_gate fpg_checker #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .nv_init_n      (nv_init_n),
    .set_valid      (set_valid),
    .set_data       (set_data),
    .acc_valid      (acc_valid),
    .acc_kind       (acc_kind),
    .acc_from_flash (acc_from_flash),
    .acc_allow      (acc_allow),
    .rd_data        (rd_data),
    .err_flag       (err_flag),
    .prot_q         (prot_q),
    .btu_q          (btu_q),
    .ctu_q          (ctu_q),
    .rdmode_q       (rdmode_q),
    .blk_idx        (blk_idx)
);

// File: tb/flash_prot_gate_tb_top.sv
// Directed bench for flash_prot_gate: one task per scenario.
module flash_prot_gate_tb_top;
    localparam int          CLK_P  = 10;
    localparam int          ADDR_W = 18;
    localparam logic [15:0] ARR    = 16'h1234;

    logic              clk = 1'b0;
    logic              rst_n, nv_init_n, set_valid, btu_cmd, rdprot_cmd, err_clr;
    logic [15:0]       set_data, acc_wdata;
    logic              acc_valid, acc_from_flash;
    logic [1:0]        acc_kind;
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_allow, err_flag;
    logic [15:0]       rd_data;

    int          checks = 0;
    int          errors = 0;
    logic [15:0] exp_prot;

    always #(CLK_P / 2) clk = ~clk;

    flash_prot_gate #(.ADDR_W(ADDR_W), .NUM_BLOCKS(7)) dut_i (
        .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n),
        .set_valid(set_valid), .set_data(set_data), .btu_cmd(btu_cmd),
        .rdprot_cmd(rdprot_cmd), .err_clr(err_clr), .acc_valid(acc_valid),
        .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_from_flash(acc_from_flash), .arr_rdata(ARR),
        .acc_allow(acc_allow), .rd_data(rd_data), .err_flag(err_flag)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] k, input logic [ADDR_W-1:0] a, input logic [15:0] d,
                      input logic ff, output logic al, output logic [15:0] rd);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = k; acc_addr = a; acc_wdata = d; acc_from_flash = ff;
        #1;
        al = acc_allow; rd = rd_data;
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic set_prot(input logic [15:0] d);
        @(negedge clk); set_valid = 1'b1; set_data = d;
        @(posedge clk); #1; set_valid = 1'b0;
    endtask

    task automatic pulse_btu;
        @(negedge clk); btu_cmd = 1'b1;
        @(posedge clk); #1; btu_cmd = 1'b0;
    endtask

    task automatic clear_err;
        @(negedge clk); err_clr = 1'b1;
        @(posedge clk); #1; err_clr = 1'b0;
    endtask

    task automatic soft_reset;
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
    endtask

    // Reads the protection word through the read-protection command, then closes the mode.
    task automatic read_word(output logic [15:0] v);
        logic al;
        logic [15:0] dummy;
        @(negedge clk); rdprot_cmd = 1'b1;
        @(posedge clk); #1; rdprot_cmd = 1'b0;
        op(2'd0, 18'h00100, 16'h0, 1'b0, al, v);
        op(2'd1, 18'h00100, 16'h0000, 1'b0, al, dummy);
    endtask

    task automatic t_reset_state;
        logic [15:0] v;
        logic al;
        logic [15:0] rd;
        read_word(v);
        chk("R1 word after cold start", v, 16'hFFFF);
        chk("R1 err after reset", {15'h0, err_flag}, 16'h0);
        op(2'd2, 18'h00010, 16'h0, 1'b1, al, rd);
        chk("R4 program unlocked block0", {15'h0, al}, 16'h1);
    endtask

    task automatic t_set_and_reject;
        logic [15:0] v;
        set_prot(16'hFFFE); exp_prot = 16'hFFFE;
        read_word(v);
        chk("R2 clear block0", v, exp_prot);
        set_prot(16'hFFFD);
        chk("R3 reject sets err", {15'h0, err_flag}, 16'h1);
        read_word(v);
        chk("R3 word unchanged after reject", v, exp_prot);
        clear_err;
        chk("R3 err cleared", {15'h0, err_flag}, 16'h0);
        set_prot(16'hFFFC); exp_prot = 16'hFFFC;
        read_word(v);
        chk("R2 clear block1", v, exp_prot);
    endtask

    task automatic t_unimpl;
        logic [15:0] v;
        set_prot(16'h807C);
        chk("R10 no error on unimplemented clears", {15'h0, err_flag}, 16'h0);
        read_word(v);
        chk("R10 unimplemented bits stay 1", v, exp_prot);
    endtask

    task automatic t_block_gate;
        logic al;
        logic [15:0] rd;
        logic [15:0] v;
        op(2'd2, 18'h03FFE, 16'h0, 1'b1, al, rd);
        chk("R4 program block0 refused", {15'h0, al}, 16'h0);
        chk("R4 refusal raises err", {15'h0, err_flag}, 16'h1);
        clear_err;
        op(2'd3, 18'h05000, 16'h0, 1'b1, al, rd);
        chk("R4 erase block1 refused", {15'h0, al}, 16'h0);
        clear_err;
        op(2'd2, 18'h06000, 16'h0, 1'b1, al, rd);
        chk("R4 program block2 allowed", {15'h0, al}, 16'h1);
        op(2'd3, 18'h20000, 16'h0, 1'b1, al, rd);
        chk("R4 erase block5 allowed", {15'h0, al}, 16'h1);
        chk("R4 no err when allowed", {15'h0, err_flag}, 16'h0);
        read_word(v);
        chk("R9 erase keeps word", v, exp_prot);
    endtask

    task automatic t_btu;
        logic al;
        logic [15:0] rd;
        logic [15:0] v;
        pulse_btu;
        op(2'd2, 18'h00020, 16'h0, 1'b1, al, rd);
        chk("R5 override lets block0 program", {15'h0, al}, 16'h1);
        op(2'd3, 18'h04000, 16'h0, 1'b1, al, rd);
        chk("R5 override persists for erase", {15'h0, al}, 16'h1);
        soft_reset;
        read_word(v);
        chk("R1 word kept over reset", v, exp_prot);
        op(2'd2, 18'h00020, 16'h0, 1'b1, al, rd);
        chk("R5 override gone after reset", {15'h0, al}, 16'h0);
        clear_err;
    endtask

    task automatic t_code;
        logic al;
        logic [15:0] rd;
        set_prot(16'h7FFC); exp_prot = 16'h7FFC;
        op(2'd0, 18'h00100, 16'h0, 1'b0, al, rd);
        chk("R6 external read hidden", rd, 16'h009B);
        op(2'd0, 18'h00100, 16'h0, 1'b1, al, rd);
        chk("R6 flash read visible", rd, ARR);
        op(2'd1, 18'h00200, 16'hFBFF, 1'b1, al, rd);
        op(2'd0, 18'h00100, 16'h0, 1'b0, al, rd);
        chk("R7 FBFF ignored", rd, 16'h009B);
        op(2'd1, 18'h00200, 16'hFFFF, 1'b0, al, rd);
        op(2'd0, 18'h00100, 16'h0, 1'b0, al, rd);
        chk("R7 external open ignored", rd, 16'h009B);
        op(2'd1, 18'h00200, 16'hFFFF, 1'b1, al, rd);
        op(2'd0, 18'h00100, 16'h0, 1'b0, al, rd);
        chk("R7 override opens", rd, ARR);
        op(2'd1, 18'h00200, 16'hFFFB, 1'b1, al, rd);
        op(2'd0, 18'h00100, 16'h0, 1'b0, al, rd);
        chk("R7 override shuts", rd, 16'h009B);
        op(2'd1, 18'h00200, 16'hFFFF, 1'b1, al, rd);
        soft_reset;
        op(2'd0, 18'h00100, 16'h0, 1'b0, al, rd);
        chk("R1 reset shuts code override", rd, 16'h009B);
    endtask

    task automatic t_rdmode;
        logic al;
        logic [15:0] rd;
        @(negedge clk); rdprot_cmd = 1'b1;
        @(posedge clk); #1; rdprot_cmd = 1'b0;
        op(2'd0, 18'h00100, 16'h0, 1'b1, al, rd);
        chk("R8 first read gives word", rd, exp_prot);
        op(2'd0, 18'h30000, 16'h0, 1'b1, al, rd);
        chk("R8 mode held across reads", rd, exp_prot);
        op(2'd2, 18'h30000, 16'h0, 1'b1, al, rd);
        op(2'd0, 18'h00100, 16'h0, 1'b1, al, rd);
        chk("R8 program ends mode", rd, ARR);
    endtask

    initial begin
        rst_n = 1'b0; nv_init_n = 1'b0; set_valid = 1'b0; set_data = '0;
        btu_cmd = 1'b0; rdprot_cmd = 1'b0; err_clr = 1'b0; acc_valid = 1'b0;
        acc_kind = '0; acc_addr = '0; acc_wdata = '0; acc_from_flash = 1'b0;
        exp_prot = 16'hFFFF;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1; nv_init_n = 1'b1;
        t_reset_state;
        t_set_and_reject;
        t_unimpl;
        t_block_gate;
        t_btu;
        t_code;
        t_rdmode;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule